// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit owns the program counter of a simple in-order core. Each cycle an instruction retires, the core presents the 32-bit instruction word together with the two source register values named by the instruction's register fields, and pulses `step`. The unit then picks the following PC. The choices are a relative branch when a register comparison holds, a jump or call through a register, or a PC-relative jump or call. Every other instruction advances the PC by one word. Calls also return a link write that the core applies to its register file.

A raise instruction does not redirect the PC by itself. Instead the unit emits a one-cycle trap request that carries the instruction's 26-bit code, and it freezes the PC. The PC stays frozen until the exception logic loads a handler address on the vector port. Register-jump instructions whose source is one of the three return registers are flagged, so that surrounding logic can tell a plain return from an exception or breakpoint return.

Top module: `next_pc_unit`

## Requirements
- R1: After reset, `pc` equals the parameter `RESET_VEC` (default 0x100), `trap_wait` is 0 and `trap_req` is 0.
- R2: A cycle without `step` or `vec_load` leaves `pc` unchanged. A step of an instruction that is not a control opcode (the opcode is bits 31:26) moves `pc` to `pc+4`.
- R3: Opcodes 17, 23, 18, 19, 21 and 20 compare `src_a` with `src_b` for equal, not-equal, signed greater, signed greater-or-equal, unsigned greater and unsigned greater-or-equal. When the comparison holds, `pc` becomes `pc` plus bits 15:0 sign-extended and shifted left by 2.
- R4: A conditional branch whose comparison fails moves `pc` to `pc+4`.
- R5: Opcode 48 sets `pc` to `src_a`. In that step cycle `ret_kind` is 1, 2 or 3 when bits 25:21 are 29, 30 or 31. In every other cycle it is 0.
- R6: Opcode 56 sets `pc` to `pc` plus bits 25:0 sign-extended and shifted left by 2.
- R7: Opcode 54 (target `src_a`) and opcode 62 (target as in R6) redirect `pc`. In the same step cycle they raise `link_we` with `link_idx` = 29 and `link_data` = the old `pc+4`. No other instruction raises `link_we`.
- R8: Opcode 43 raises `trap_req` for exactly one cycle, with `trap_code` equal to bits 25:0 (2 = breakpoint, 7 = system call). It then sets `trap_wait` and holds `pc`.
- R9: While `trap_wait` is 1, steps are ignored. `pc` does not move, and neither `link_we` nor `trap_req` is raised.
- R10: `vec_load` loads `pc` from `vec_addr` and clears `trap_wait`. It takes priority over a `step` in the same cycle, and that step has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction retires this cycle |
| instr | input | 32 | Retiring instruction word |
| src_a | input | 32 | Value of register named by bits 25:21 |
| src_b | input | 32 | Value of register named by bits 20:16 |
| vec_load | input | 1 | Load handler address |
| vec_addr | input | 32 | Handler address |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |
| ret_kind | output | 2 | Return flavour of a register jump |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 26 | Code carried by the raise |
| trap_wait | output | 1 | PC frozen awaiting vector |

## Verification
Assertions cover the cycle-level rules that apply on every edge. An idle cycle holds the PC, and a register jump lands on the sampled register value. The trap pulse lasts one cycle and is followed by the frozen state, which holds the PC until a vector load sets it to the supplied address. The arithmetic of each branch condition and offset can only be shown by the bench's scenarios. These include signed and unsigned comparisons with a negative operand, backward offsets, the link address of both call forms, the three return flavours, and a step that collides with a vector load.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter int          LINK_REG  = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            vec_load,
  input  logic [XLEN-1:0] vec_addr,
  output logic [XLEN-1:0] pc,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_data,
  output logic [1:0]      ret_kind,
  output logic            trap_req,
  output logic [25:0]     trap_code,
  output logic            trap_wait
);
  localparam logic [5:0] OP_BEQ = 6'd17, OP_BNE = 6'd23, OP_BGT = 6'd18,
                         OP_BGE = 6'd19, OP_BGTU = 6'd21, OP_BGEU = 6'd20;
  localparam logic [5:0] OP_JR = 6'd48, OP_CALLR = 6'd54, OP_JI = 6'd56,
                         OP_CALLI = 6'd62, OP_RAISE = 6'd43;

  logic [5:0]      op;
  logic [4:0]      ra_idx;
  logic            fire, cond;
  logic [XLEN-1:0] seq_pc, br_pc, far_pc, nxt_pc;

  assign op     = instr[31:26];
  assign ra_idx = instr[25:21];
  assign fire   = step && !trap_wait && !vec_load;
  assign seq_pc = pc + XLEN'(4);
  assign br_pc  = pc + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign far_pc = pc + {{(XLEN-28){instr[25]}}, instr[25:0], 2'b00};

  always_comb begin
    case (op)
      OP_BEQ:  cond = (src_a == src_b);
      OP_BNE:  cond = (src_a != src_b);
      OP_BGT:  cond = ($signed(src_a) >  $signed(src_b));
      OP_BGE:  cond = ($signed(src_a) >= $signed(src_b));
      OP_BGTU: cond = (src_a >  src_b);
      OP_BGEU: cond = (src_a >= src_b);
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_BEQ, OP_BNE, OP_BGT, OP_BGE, OP_BGTU, OP_BGEU:
                         nxt_pc = cond ? br_pc : seq_pc;
      OP_JR, OP_CALLR:   nxt_pc = src_a;
      OP_JI, OP_CALLI:   nxt_pc = far_pc;
      OP_RAISE:          nxt_pc = pc;
      default:           nxt_pc = seq_pc;
    endcase
  end

  assign link_we   = fire && (op == OP_CALLR || op == OP_CALLI);
  assign link_idx  = 5'(LINK_REG);
  assign link_data = seq_pc;
  assign trap_req  = fire && (op == OP_RAISE);
  assign trap_code = instr[25:0];

  always_comb begin
    ret_kind = 2'd0;
    if (fire && op == OP_JR) begin
      case (ra_idx)
        5'd29:   ret_kind = 2'd1;
        5'd30:   ret_kind = 2'd2;
        5'd31:   ret_kind = 2'd3;
        default: ret_kind = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= RESET_VEC[XLEN-1:0];
      trap_wait <= 1'b0;
    end else if (vec_load) begin
      pc        <= vec_addr;
      trap_wait <= 1'b0;
    end else if (fire) begin
      pc <= nxt_pc;
      if (op == OP_RAISE) trap_wait <= 1'b1;
    end
  end

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !vec_load) |=> $stable(pc));

  a_r5_regjump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trap_wait && !vec_load && instr[31:26] == 6'd48) |=> pc == $past(src_a));

  a_r8_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req && trap_wait);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_wait && !vec_load) |=> $stable(pc) && trap_wait);

  a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> pc == $past(vec_addr) && !trap_wait);

  a_r7_link_excl: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> !trap_req && ret_kind == 2'd0);
endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, step = 0, vec_load = 0;
  logic [31:0] instr = 0, src_a = 0, src_b = 0, vec_addr = 0;
  logic [31:0] pc, link_data;
  logic        link_we, trap_req, trap_wait;
  logic [4:0]  link_idx;
  logic [1:0]  ret_kind;
  logic [25:0] trap_code;

  int total = 0, bad = 0;
  logic        s_we, s_trap;
  logic [4:0]  s_idx;
  logic [31:0] s_ldata;
  logic [1:0]  s_kind;
  logic [25:0] s_code;

  next_pc_unit dut (.clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
    .src_a(src_a), .src_b(src_b), .vec_load(vec_load), .vec_addr(vec_addr),
    .pc(pc), .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
    .ret_kind(ret_kind), .trap_req(trap_req), .trap_code(trap_code),
    .trap_wait(trap_wait));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(logic [5:0] op, logic [4:0] ra, logic [4:0] rb, logic [15:0] off);
    return {op, ra, rb, off};
  endfunction

  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] off);
    return {op, off};
  endfunction

  task automatic do_step(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    instr = ins; src_a = a; src_b = b; step = 1;
    #1;
    s_we = link_we; s_idx = link_idx; s_ldata = link_data;
    s_kind = ret_kind; s_trap = trap_req; s_code = trap_code;
    @(negedge clk);
    step = 0; instr = 0;
  endtask

  task automatic load_vec(logic [31:0] addr);
    @(negedge clk);
    vec_load = 1; vec_addr = addr;
    @(negedge clk);
    vec_load = 0;
  endtask

  task automatic t_reset;
    check("R1 pc", pc, 32'h100);
    check("R1 trap_wait", 32'(trap_wait), 0);
    check("R1 trap_req", 32'(trap_req), 0);
  endtask

  task automatic t_sequential;
    logic [31:0] p;
    p = pc;
    do_step(enc_b(6'd45, 5'd1, 5'd2, 16'h0), 0, 0);
    check("R2 add steps by 4", pc, p + 4);
    check("R7 no link on add", 32'(s_we), 0);
    p = pc;
    repeat (3) @(negedge clk);
    check("R2 idle hold", pc, p);
  endtask

  task automatic branch_case(string tag, logic [5:0] op, logic [31:0] a, logic [31:0] b,
                             logic [15:0] off, bit taken);
    logic [31:0] p, e;
    p = pc;
    e = taken ? p + {{14{off[15]}}, off, 2'b00} : p + 4;
    do_step(enc_b(op, 5'd3, 5'd4, off), a, b);
    check(tag, pc, e);
  endtask

  task automatic t_branches;
    load_vec(32'h0000_4000);
    branch_case("R3 beq taken",   6'd17, 5, 5, 16'h0010, 1);
    branch_case("R4 beq not",     6'd17, 5, 6, 16'h0010, 0);
    branch_case("R3 bne taken back", 6'd23, 1, 2, 16'hFFFC, 1);
    branch_case("R4 bne not",     6'd23, 7, 7, 16'h0008, 0);
    branch_case("R3 bgt signed",  6'd18, 32'h1, 32'hFFFF_FFFF, 16'h0004, 1);
    branch_case("R4 bgt neg",     6'd18, 32'hFFFF_FFFF, 32'h1, 16'h0004, 0);
    branch_case("R3 bge equal",   6'd19, 9, 9, 16'h0020, 1);
    branch_case("R4 bge less",    6'd19, 32'h8000_0000, 0, 16'h0020, 0);
    branch_case("R3 bgtu big",    6'd21, 32'hFFFF_FFFF, 32'h1, 16'h0002, 1);
    branch_case("R4 bgtu equal",  6'd21, 3, 3, 16'h0002, 0);
    branch_case("R3 bgeu equal",  6'd20, 3, 3, 16'hFF00, 1);
    branch_case("R4 bgeu less",   6'd20, 1, 32'hFFFF_FFFF, 16'h0002, 0);
  endtask

  task automatic t_jumps;
    logic [31:0] p;
    do_step(enc_b(6'd48, 5'd7, 5'd0, 16'h0), 32'h0000_2468, 0);
    check("R5 jr target", pc, 32'h2468);
    check("R5 jr plain kind", 32'(s_kind), 0);
    do_step(enc_b(6'd48, 5'd29, 5'd0, 16'h0), 32'h0000_3000, 0);
    check("R5 ret kind", 32'(s_kind), 1);
    do_step(enc_b(6'd48, 5'd30, 5'd0, 16'h0), 32'h0000_3100, 0);
    check("R5 eret kind", 32'(s_kind), 2);
    do_step(enc_b(6'd48, 5'd31, 5'd0, 16'h0), 32'h0000_3200, 0);
    check("R5 bret kind", 32'(s_kind), 3);
    check("R5 bret target", pc, 32'h3200);
    p = pc;
    do_step(enc_j(6'd56, 26'h3FF_FFF0), 0, 0);
    check("R6 ji backward", pc, p - 32'h40);
    p = pc;
    do_step(enc_j(6'd56, 26'h000_0100), 0, 0);
    check("R6 ji forward", pc, p + 32'h400);
  endtask

  task automatic t_calls;
    logic [31:0] p;
    p = pc;
    do_step(enc_b(6'd54, 5'd5, 5'd0, 16'h0), 32'h0000_8000, 0);
    check("R7 callr target", pc, 32'h8000);
    check("R7 callr we", 32'(s_we), 1);
    check("R7 callr idx", 32'(s_idx), 29);
    check("R7 callr data", s_ldata, p + 4);
    p = pc;
    do_step(enc_j(6'd62, 26'h3FF_FFFE), 0, 0);
    check("R7 calli target", pc, p - 8);
    check("R7 calli data", s_ldata, p + 4);
  endtask

  task automatic t_trap;
    logic [31:0] p;
    p = pc;
    do_step(enc_j(6'd43, 26'd7), 0, 0);
    check("R8 trap req", 32'(s_trap), 1);
    check("R8 trap code", 32'(s_code), 7);
    check("R8 pc held", pc, p);
    check("R8 pulse gone", 32'(trap_req), 0);
    check("R8 wait set", 32'(trap_wait), 1);
    do_step(enc_j(6'd62, 26'h10), 0, 0);
    check("R9 no link while frozen", 32'(s_we), 0);
    check("R9 pc frozen", pc, p);
    do_step(enc_j(6'd43, 26'd2), 0, 0);
    check("R9 no second trap", 32'(s_trap), 0);
    load_vec(32'h0000_0800);
    check("R10 vector pc", pc, 32'h800);
    check("R10 wait cleared", 32'(trap_wait), 0);
    do_step(enc_j(6'd43, 26'd2), 0, 0);
    check("R8 break code", 32'(s_code), 2);
    load_vec(32'h0000_0900);
  endtask

  task automatic t_collide;
    @(negedge clk);
    vec_load = 1; vec_addr = 32'h0000_0A00;
    step = 1; instr = enc_j(6'd62, 26'h40);
    #1;
    check("R10 step suppressed link", 32'(link_we), 0);
    @(negedge clk);
    vec_load = 0; step = 0; instr = 0;
    check("R10 vector wins", pc, 32'hA00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sequential;
    t_branches;
    t_jumps;
    t_calls;
    t_trap;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule